// File: doc/BRIEF.md
# Backplane Connection Admission Checker

This block sits in the control plane of a timeslot switch. It receives make and break requests for simplex connections. Each request names a source and a destination as a stream and a timeslot. For each request it decides whether the switch may carry the connection and answers with a grant flag and a reason code. It also reports the direction that now applies to each backplane timeslot pair the request touched, so the switch datapath can program its line drivers.

Backplane streams come in pairs that share one direction setting per timeslot. Logical stream `s` below `2*NPAIR` sits on physical line `s>>1`. An even `s` is that line's "out" side and an odd `s` is its "in" side. The first connection that uses a pair fixes which side carries data into the switch. A connection that needs the other side is refused until every connection on the pair has been broken. Local streams have no direction. Backplane connections and local-to-local connections are counted against separate limits.

A destination can be driven by only one source, and the block keeps a record of which source drives it. That record is what lets a break be matched against an existing connection.

Top module: `conn_admit`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, no connection exists and every timeslot pair has direction 0 (unset).
- R2: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` is 0 in the following cycle. Exactly one response, a one-cycle `rsp_valid` pulse, appears in the cycle after that.
- R3: Opcode 0 is make and 1 is break. Stream numbers below `2*NPAIR` are backplane streams; stream `s` uses pair line `s>>1` at its own timeslot. Direction code 1 means the even stream of the pair feeds the switch and the odd stream is driven by it. Code 2 is the reverse. A source on stream `s` needs code 1 if `s` is even and code 2 if `s` is odd. A destination on stream `s` needs code 2 if `s` is even and code 1 if `s` is odd.
- R4: A granted make sets each touched backplane pair to the code it needs. `rsp_src_dir` and `rsp_dst_dir` report the pair directions after the request.
- R5: A make that needs a different code on a pair whose direction is already set is rejected with reason 1 (BLOCKED), and no state changes.
- R6: Each pair keeps a 6-bit count of connection ends that use it. A pair's direction stays set until a granted break brings its count to zero, which returns it to 0. A make that would push a count past 63 is rejected with reason 2.
- R7: Local streams never carry a direction and are never blocked by one. The reported direction for a local endpoint is always 0.
- R8: A connection with at least one backplane end uses one unit of a `BP_UNITS` budget. A make that finds the budget full is rejected with reason 2 (CAPACITY).
- R9: A connection with both ends local counts against `LOC_LIMIT` and not against the backplane budget. A make that finds that limit reached is rejected with reason 2.
- R10: A break whose destination is not currently driven by the named source returns reason 3 (NOT_FOUND) and changes no state.
- R11: A make toward a destination that already has a source is rejected with reason 1.
- R12: When both ends of a request fall on the same pair at the same timeslot, the count moves by two. If the two ends need different codes, the make is rejected with reason 1. A granted request has reason 0 (OK) and `rsp_grant` 1, and every other response has `rsp_grant` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 1 | 0 make, 1 break |
| req_src_str | input | SW | Source stream |
| req_src_ts | input | TW | Source timeslot |
| req_dst_str | input | SW | Destination stream |
| req_dst_ts | input | TW | Destination timeslot |
| rsp_valid | output | 1 | Response pulse |
| rsp_grant | output | 1 | Request granted |
| rsp_reason | output | 2 | 0 OK, 1 BLOCKED, 2 CAPACITY, 3 NOT_FOUND |
| rsp_src_dir | output | 2 | Direction of the source pair after the request |
| rsp_dst_dir | output | 2 | Direction of the destination pair after the request |

## Verification
Two updates can fall on the same pair in the same cycle. This happens when the source and destination are the two lines of one pair at one timeslot: the direction check and the count update then act on a single entry. The bench provokes it with a make from even to odd stream at one timeslot, which must be granted. It then tries a make from even to even stream at that timeslot, which must be blocked. Finally it breaks the first connection and expects the direction to return to 0 at once, which shows that the count rose and fell by two. Releasing a pair and claiming it again in the opposite direction is checked in the same way, from the directions reported at the ports.

// File: rtl/conn_admit.sv
module conn_admit #(
  parameter int SW        = 4,
  parameter int TW        = 5,
  parameter int NPAIR     = 4,
  parameter int BP_UNITS  = 256,
  parameter int LOC_LIMIT = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_op,
  input  logic [SW-1:0] req_src_str,
  input  logic [TW-1:0] req_src_ts,
  input  logic [SW-1:0] req_dst_str,
  input  logic [TW-1:0] req_dst_ts,
  output logic          rsp_valid,
  output logic          rsp_grant,
  output logic [1:0]    rsp_reason,
  output logic [1:0]    rsp_src_dir,
  output logic [1:0]    rsp_dst_dir
);
  localparam int LW   = $clog2(NPAIR);
  localparam int NPP  = NPAIR << TW;
  localparam int NEND = 1 << (SW + TW);
  localparam int BW   = $clog2(BP_UNITS + 1);
  localparam int CW   = $clog2(LOC_LIMIT + 1);
  localparam logic [1:0] D_UNSET = 2'd0, D_EVEN = 2'd1, D_ODD = 2'd2;
  localparam logic [1:0] R_OK = 2'd0, R_BLK = 2'd1, R_CAP = 2'd2, R_NOTF = 2'd3;

  logic          busy, r_op;
  logic [SW-1:0] r_ss, r_ds;
  logic [TW-1:0] r_st, r_dt;

  logic               dst_used [NEND];
  logic [SW+TW-1:0]   dst_src  [NEND];
  logic [1:0]         pdir     [NPP];
  logic [5:0]         pcnt     [NPP];
  logic [BW-1:0]      bp_units;
  logic [CW-1:0]      loc_cnt;

  assign req_ready = !busy;
  wire accept = req_valid && req_ready;

  wire [SW+TW-1:0] s_ep = {r_ss, r_st};
  wire [SW+TW-1:0] d_ep = {r_ds, r_dt};
  wire [LW+TW-1:0] s_pi = {r_ss[LW:1], r_st};
  wire [LW+TW-1:0] d_pi = {r_ds[LW:1], r_dt};
  wire s_bp = r_ss < SW'(2 * NPAIR);
  wire d_bp = r_ds < SW'(2 * NPAIR);
  wire same = s_bp && d_bp && (s_pi == d_pi);

  wire [1:0] need_s = r_ss[0] ? D_ODD : D_EVEN;
  wire [1:0] need_d = r_ds[0] ? D_EVEN : D_ODD;
  wire [1:0] s_dir  = pdir[s_pi];
  wire [1:0] d_dir  = pdir[d_pi];
  wire [5:0] s_cnt  = pcnt[s_pi];
  wire [5:0] d_cnt  = pcnt[d_pi];
  wire [5:0] step   = same ? 6'd2 : 6'd1;

  wire s_ok    = !s_bp || s_dir == D_UNSET || s_dir == need_s;
  wire d_ok    = !d_bp || d_dir == D_UNSET || d_dir == need_d;
  wire dir_bad = !s_ok || !d_ok || (same && need_s != need_d);
  wire sat     = (s_bp && s_cnt > 6'd63 - step) || (d_bp && !same && d_cnt == 6'd63);
  wire bp_conn = s_bp || d_bp;
  wire full    = bp_conn ? (bp_units >= BW'(BP_UNITS)) : (loc_cnt >= CW'(LOC_LIMIT));
  wire found   = dst_used[d_ep] && dst_src[d_ep] == s_ep;

  logic [1:0] reason;
  always_comb begin
    if (r_op)                          reason = found ? R_OK : R_NOTF;
    else if (dst_used[d_ep] || dir_bad) reason = R_BLK;
    else if (full || sat)               reason = R_CAP;
    else                                reason = R_OK;
  end
  wire grant = reason == R_OK;

  wire [5:0] s_cnt_nx = r_op ? s_cnt - step : s_cnt + step;
  wire [5:0] d_cnt_nx = r_op ? d_cnt - 6'd1 : d_cnt + 6'd1;

  logic [1:0] s_dir_nx, d_dir_nx;
  always_comb begin
    if (!s_bp)       s_dir_nx = D_UNSET;
    else if (!grant) s_dir_nx = s_dir;
    else if (r_op)   s_dir_nx = (s_cnt_nx == 6'd0) ? D_UNSET : s_dir;
    else             s_dir_nx = need_s;

    if (same)        d_dir_nx = s_dir_nx;
    else if (!d_bp)  d_dir_nx = D_UNSET;
    else if (!grant) d_dir_nx = d_dir;
    else if (r_op)   d_dir_nx = (d_cnt_nx == 6'd0) ? D_UNSET : d_dir;
    else             d_dir_nx = need_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_grant   <= 1'b0;
      rsp_reason  <= R_OK;
      rsp_src_dir <= D_UNSET;
      rsp_dst_dir <= D_UNSET;
      r_op        <= 1'b0;
      r_ss        <= '0;
      r_ds        <= '0;
      r_st        <= '0;
      r_dt        <= '0;
      bp_units    <= '0;
      loc_cnt     <= '0;
      for (int i = 0; i < NEND; i++) begin
        dst_used[i] <= 1'b0;
        dst_src[i]  <= '0;
      end
      for (int i = 0; i < NPP; i++) begin
        pdir[i] <= D_UNSET;
        pcnt[i] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        r_op <= req_op;
        r_ss <= req_src_str;
        r_st <= req_src_ts;
        r_ds <= req_dst_str;
        r_dt <= req_dst_ts;
      end
      if (busy) begin
        busy        <= 1'b0;
        rsp_valid   <= 1'b1;
        rsp_grant   <= grant;
        rsp_reason  <= reason;
        rsp_src_dir <= s_dir_nx;
        rsp_dst_dir <= d_dir_nx;
        if (grant) begin
          dst_used[d_ep] <= !r_op;
          if (!r_op) dst_src[d_ep] <= s_ep;
          if (s_bp) begin
            pcnt[s_pi] <= s_cnt_nx;
            pdir[s_pi] <= s_dir_nx;
          end
          if (d_bp && !same) begin
            pcnt[d_pi] <= d_cnt_nx;
            pdir[d_pi] <= d_dir_nx;
          end
          if (bp_conn) bp_units <= r_op ? bp_units - BW'(1) : bp_units + BW'(1);
          else         loc_cnt  <= r_op ? loc_cnt - CW'(1)  : loc_cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/conn_admit_chk.sv
module conn_admit_chk #(
  parameter int SW        = 4,
  parameter int NPAIR     = 4,
  parameter int BP_UNITS  = 256,
  parameter int LOC_LIMIT = 1024
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             req_valid,
  input logic                             req_ready,
  input logic                             rsp_valid,
  input logic                             rsp_grant,
  input logic [1:0]                       rsp_src_dir,
  input logic                             r_op,
  input logic [SW-1:0]                    r_ss,
  input logic [$clog2(BP_UNITS+1)-1:0]    bp_units,
  input logic [$clog2(LOC_LIMIT+1)-1:0]   loc_cnt
);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

  assert_rsp_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 rsp_valid);

  assert_rsp_has_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$past(rsp_valid));

  assert_make_sets_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant && !r_op && r_ss < SW'(2 * NPAIR)) |-> rsp_src_dir != 2'd0);

  assert_local_no_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !(r_ss < SW'(2 * NPAIR))) |-> rsp_src_dir == 2'd0);

  assert_budget_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bp_units <= ($clog2(BP_UNITS+1))'(BP_UNITS));

  assert_reject_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |-> (bp_units == $past(bp_units) && loc_cnt == $past(loc_cnt)));
endmodule

bind conn_admit conn_admit_chk #(
  .SW(SW), .NPAIR(NPAIR), .BP_UNITS(BP_UNITS), .LOC_LIMIT(LOC_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_src_dir(rsp_src_dir),
  .r_op(r_op), .r_ss(r_ss), .bp_units(bp_units), .loc_cnt(loc_cnt)
);

// File: tb/conn_admit_tb.sv
`timescale 1ns/1ps
module conn_admit_tb;
  localparam int SW = 4, TW = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0;
  logic [SW-1:0] req_src_str = '0, req_dst_str = '0;
  logic [TW-1:0] req_src_ts = '0, req_dst_ts = '0;
  logic req_ready, rsp_valid, rsp_grant;
  logic [1:0] rsp_reason, rsp_src_dir, rsp_dst_dir;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  conn_admit #(.SW(SW), .TW(TW), .NPAIR(4), .BP_UNITS(6), .LOC_LIMIT(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src_str(req_src_str), .req_src_ts(req_src_ts),
    .req_dst_str(req_dst_str), .req_dst_ts(req_dst_ts), .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant), .rsp_reason(rsp_reason), .rsp_src_dir(rsp_src_dir),
    .rsp_dst_dir(rsp_dst_dir));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic req(input string tag, input bit op, input int ss, input int st,
                     input int ds, input int dt, input int rsn, input int sd, input int dd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op;
    req_src_str = SW'(ss); req_src_ts = TW'(st);
    req_dst_str = SW'(ds); req_dst_ts = TW'(dt);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 ready low while deciding"}, int'(req_ready), 0);
    chk({tag, " R2 no early response"}, int'(rsp_valid), 0);
    @(negedge clk);
    chk({tag, " R2 response present"}, int'(rsp_valid), 1);
    chk({tag, " reason"}, int'(rsp_reason), rsn);
    chk({tag, " R12 grant matches reason"}, int'(rsp_grant), int'(rsn == 0));
    chk({tag, " src dir"}, int'(rsp_src_dir), sd);
    chk({tag, " dst dir"}, int'(rsp_dst_dir), dd);
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", int'(req_ready), 1);
    chk("R1 no response after reset", int'(rsp_valid), 0);
    req("R1 fresh pair unset", 1'b1, 0, 3, 5, 6, 3, 0, 0);
  endtask

  task automatic t_duplex;
    req("R4 first make 0:3->5:6", 1'b0, 0, 3, 5, 6, 0, 1, 1);
    req("R3 reverse make 4:6->1:3", 1'b0, 4, 6, 1, 3, 0, 1, 1);
  endtask

  task automatic t_block;
    req("R5 opposite direction", 1'b0, 1, 3, 8, 0, 1, 1, 0);
    req("R11 destination taken", 1'b0, 2, 0, 5, 6, 1, 0, 1);
  endtask

  task automatic t_release;
    req("R10 break unknown", 1'b1, 2, 0, 5, 6, 3, 0, 1);
    req("R6 break keeps dir", 1'b1, 0, 3, 5, 6, 0, 1, 1);
    req("R6 last break clears", 1'b1, 4, 6, 1, 3, 0, 0, 0);
    req("R6 reclaim opposite", 1'b0, 1, 3, 8, 0, 0, 2, 0);
  endtask

  task automatic t_same_pair;
    req("R12 same pair make", 1'b0, 0, 7, 1, 7, 0, 1, 1);
    req("R12 same pair conflict", 1'b0, 0, 7, 0, 7, 1, 1, 1);
    req("R12 same pair break", 1'b1, 0, 7, 1, 7, 0, 0, 0);
    req("R12 same pair reverse", 1'b0, 1, 7, 0, 7, 0, 2, 2);
    req("R12 same pair reverse break", 1'b1, 1, 7, 0, 7, 0, 0, 0);
  endtask

  task automatic t_bp_cap;
    for (int t = 10; t < 15; t++) req("R8 fill budget", 1'b0, 8, t, 0, t, 0, 0, 2);
    req("R8 budget full", 1'b0, 8, 20, 0, 20, 2, 0, 0);
    req("R8 free one unit", 1'b1, 8, 10, 0, 10, 0, 0, 0);
    req("R8 retry after free", 1'b0, 8, 20, 0, 20, 0, 0, 2);
  endtask

  task automatic t_local;
    req("R7 local make", 1'b0, 9, 0, 10, 0, 0, 0, 0);
    req("R7 local fanout", 1'b0, 9, 0, 11, 0, 0, 0, 0);
    req("R9 local third", 1'b0, 9, 1, 10, 1, 0, 0, 0);
    req("R9 local limit", 1'b0, 9, 2, 10, 2, 2, 0, 0);
    req("R9 free backplane unit", 1'b1, 8, 11, 0, 11, 0, 0, 0);
    req("R9 backplane unaffected", 1'b0, 8, 21, 1, 21, 0, 0, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_duplex();
    t_block();
    t_release();
    t_same_pair();
    t_bp_cap();
    t_local();
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule